// File: doc/BRIEF.md
# External Low-Frequency Oscillator Stop Monitor with Clock Failover

The block watches a 32.768 kHz external oscillator from the system clock domain. The external clock passes through a synchronizer. Each edge seen after it restarts a timeout counter. If no edge arrives within a programmable number of system cycles, the oscillator counts as stopped. A live status bit follows that condition at all times.

When monitoring is armed (the monitor enable is set and the external source is selected) and a stop is seen, a sticky failure flag sets. A one-cycle non-maskable interrupt request pulses, and a source bit names this monitor as the cause. The low-frequency clock output moves to the internal low-frequency oscillator at once, through a glitch-free switch.

The internal oscillator can run anywhere from about -70% to +127% of nominal, so any timing that depends on the output must allow for that range after failover. Software clears the flag by writing a one to it. The write is accepted only while the live status shows the external oscillator toggling again. On a successful clear, the output returns to the external clock through the same glitch-free switch and the timeout window restarts.

Top module: `xosc_watch`

## Requirements
- R1: The failure flag can set only while `mon_en` is 1 and `src_sel_ext` is 1. With either one low, a stopped external clock leaves `fail_flag` and `nmi_req` at 0.
- R2: With monitoring armed, `fail_flag` rises on the cycle after `xosc_idle` is seen at 1. It then stays at 1 until it is cleared, even if the external clock resumes.
- R3: Once `fail_flag` is 1, `lf_clk` follows `int_clk` after at most two falling edges of `int_clk`.
- R4: `xosc_idle` is 0 while the external clock toggles. It becomes 1 once TIMEOUT_CYCLES system cycles pass with no edge after the SYNC_STAGES-flop synchronizer. A synchronized edge, or an accepted clear, restarts the count from 0.
- R5: A one-cycle pulse on `clr_wr` clears `fail_flag` only when `xosc_idle` is 0 in that cycle. Otherwise `fail_flag` stays 1.
- R6: `nmi_req` is high for exactly one cycle, the cycle in which `fail_flag` rises. `nmi_src` is 1 exactly while `fail_flag` is 1.
- R7: Every high or low phase of `lf_clk` lasts at least the shorter half period of the two source clocks, including across every switch of source.
- R8: After an accepted clear, with `src_sel_ext` at 1, `lf_clk` follows `ext_clk` again.
- R9: With the external oscillator healthy, `lf_clk` follows `ext_clk` when `src_sel_ext` is 1 and follows `int_clk` when `src_sel_ext` is 0.
- R10: While `rst_n` is 0, `fail_flag`, `nmi_req`, `nmi_src` and `xosc_idle` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock that samples the external oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External 32.768 kHz oscillator clock |
| int_clk | input | 1 | Internal low-frequency oscillator clock |
| mon_en | input | 1 | Arms stop monitoring |
| src_sel_ext | input | 1 | 1 selects the external oscillator as the source |
| clr_wr | input | 1 | One-cycle write of 1 to the failure flag |
| lf_clk | output | 1 | Glitch-free low-frequency clock output |
| xosc_idle | output | 1 | Live status: 1 while the external clock is not toggling |
| fail_flag | output | 1 | Sticky stop-failure flag |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| nmi_src | output | 1 | Interrupt source bit for this monitor |

## Verification
The hardest situation to reach is a rejected clear followed by an accepted one. This needs the failure flag set, the oscillator still stopped when the first write arrives, and the oscillator toggling again before the second. The stimulus stops the external clock model, waits out the window, writes the clear once while it is stopped, then restarts the model and writes again. The oscillator is stopped once low and once high, because the switch treats a source stuck high differently from one stuck low.

// File: rtl/xosc_watch_pkg.sv
`timescale 1ns/1ps
package xosc_watch_pkg;
   localparam int unsigned SYS_HZ_NOM  = 125_000_000;
   localparam int unsigned XOSC_HZ_NOM = 32_768;
   localparam int unsigned STOP_PERIODS = 4;
   // about four nominal external periods expressed in system cycles
   localparam int unsigned TIMEOUT_DEFAULT = STOP_PERIODS * (SYS_HZ_NOM / XOSC_HZ_NOM);
   localparam int unsigned SYNC_DEFAULT = 2;
   localparam int unsigned TIMEOUT_MIN  = 4;
endpackage

// File: rtl/xosc_activity.sv
`timescale 1ns/1ps
module xosc_activity #(
   parameter int unsigned SYNC_STAGES    = xosc_watch_pkg::SYNC_DEFAULT,
   parameter int unsigned TIMEOUT_CYCLES = xosc_watch_pkg::TIMEOUT_DEFAULT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_in,
   input  logic restart,
   output logic idle
);
   localparam int unsigned CW = $clog2(TIMEOUT_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xosc_activity: SYNC_STAGES must be at least 2");
   end
   if (TIMEOUT_CYCLES < xosc_watch_pkg::TIMEOUT_MIN) begin : g_bad_timeout
      $error("xosc_activity: TIMEOUT_CYCLES too small");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic [CW-1:0]          gap_cnt;
   logic                   osc_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], osc_in};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign osc_edge = sync_q[SYNC_STAGES-1] ^ prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 gap_cnt <= '0;
      else if (restart || osc_edge) gap_cnt <= '0;
      else if (gap_cnt != LIMIT)  gap_cnt <= gap_cnt + 1'b1;
   end

   assign idle = (gap_cnt == LIMIT);
endmodule

// File: rtl/xosc_fail_ctl.sv
`timescale 1ns/1ps
module xosc_fail_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic idle,
   input  logic clr_wr,
   output logic fail_q,
   output logic nmi_pulse,
   output logic src_q,
   output logic clr_ok
);
   logic set_ev;

   assign set_ev = armed & idle & ~fail_q;
   assign clr_ok = clr_wr & fail_q & ~idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_q    <= 1'b0;
         src_q     <= 1'b0;
         nmi_pulse <= 1'b0;
      end else begin
         nmi_pulse <= set_ev;
         if (set_ev) begin
            fail_q <= 1'b1;
            src_q  <= 1'b1;
         end else if (clr_ok) begin
            fail_q <= 1'b0;
            src_q  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/lfclk_gf_mux.sv
`timescale 1ns/1ps
module lfclk_gf_mux #(
   parameter int unsigned EN_STAGES = 2
) (
   input  logic rst_n,
   input  logic want_ext,
   input  logic kill_ext,
   input  logic ext_clk,
   input  logic int_clk,
   output logic clk_out
);
   if (EN_STAGES < 2) begin : g_bad_stages
      $error("lfclk_gf_mux: EN_STAGES must be at least 2");
   end

   logic [EN_STAGES-1:0] ext_en_q;
   logic [EN_STAGES-1:0] int_en_q;
   logic                 ext_arst_n;

   // a stopped source never gives a falling edge, so a failure drops its enable directly
   assign ext_arst_n = rst_n & ~kill_ext;

   always_ff @(negedge ext_clk or negedge ext_arst_n) begin
      if (!ext_arst_n) ext_en_q <= '0;
      else             ext_en_q <= {ext_en_q[EN_STAGES-2:0], want_ext & ~int_en_q[EN_STAGES-1]};
   end

   always_ff @(negedge int_clk or negedge rst_n) begin
      if (!rst_n) int_en_q <= '0;
      else        int_en_q <= {int_en_q[EN_STAGES-2:0], ~want_ext & ~ext_en_q[EN_STAGES-1]};
   end

   assign clk_out = (ext_clk & ext_en_q[EN_STAGES-1]) | (int_clk & int_en_q[EN_STAGES-1]);
endmodule

// File: rtl/xosc_watch.sv
`timescale 1ns/1ps
module xosc_watch #(
   parameter int unsigned TIMEOUT_CYCLES = xosc_watch_pkg::TIMEOUT_DEFAULT,
   parameter int unsigned SYNC_STAGES    = xosc_watch_pkg::SYNC_DEFAULT
) (
   input  logic sys_clk,
   input  logic rst_n,
   input  logic ext_clk,
   input  logic int_clk,
   input  logic mon_en,
   input  logic src_sel_ext,
   input  logic clr_wr,
   output logic lf_clk,
   output logic xosc_idle,
   output logic fail_flag,
   output logic nmi_req,
   output logic nmi_src
);
   logic armed;
   logic restart;
   logic want_ext;

   assign armed    = mon_en & src_sel_ext;
   assign want_ext = src_sel_ext & ~fail_flag;

   xosc_activity #(
      .SYNC_STAGES    (SYNC_STAGES),
      .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
   ) i_activity (
      .clk     (sys_clk),
      .rst_n   (rst_n),
      .osc_in  (ext_clk),
      .restart (restart),
      .idle    (xosc_idle)
   );

   xosc_fail_ctl i_fail (
      .clk       (sys_clk),
      .rst_n     (rst_n),
      .armed     (armed),
      .idle      (xosc_idle),
      .clr_wr    (clr_wr),
      .fail_q    (fail_flag),
      .nmi_pulse (nmi_req),
      .src_q     (nmi_src),
      .clr_ok    (restart)
   );

   lfclk_gf_mux #(
      .EN_STAGES (SYNC_STAGES)
   ) i_mux (
      .rst_n    (rst_n),
      .want_ext (want_ext),
      .kill_ext (fail_flag),
      .ext_clk  (ext_clk),
      .int_clk  (int_clk),
      .clk_out  (lf_clk)
   );
endmodule

// File: rtl/xosc_watch_chk.sv
`timescale 1ns/1ps
module xosc_watch_chk (
   input logic sys_clk,
   input logic rst_n,
   input logic mon_en,
   input logic src_sel_ext,
   input logic clr_wr,
   input logic xosc_idle,
   input logic fail_flag,
   input logic nmi_req,
   input logic nmi_src
);
   a_r6_nmi_single: assert property (@(posedge sys_clk) disable iff (!rst_n)
      nmi_req |=> !nmi_req);

   a_r6_nmi_on_rise: assert property (@(posedge sys_clk) disable iff (!rst_n)
      nmi_req |-> (fail_flag && !$past(fail_flag)));

   a_r6_rise_has_nmi: assert property (@(posedge sys_clk) disable iff (!rst_n)
      $rose(fail_flag) |-> nmi_req);

   a_r6_src_follows_flag: assert property (@(posedge sys_clk) disable iff (!rst_n)
      nmi_src == fail_flag);

   a_r2_sticky: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (fail_flag && !clr_wr) |=> fail_flag);

   a_r2_needs_idle: assert property (@(posedge sys_clk) disable iff (!rst_n)
      $rose(fail_flag) |-> $past(xosc_idle));

   a_r5_idle_blocks_clear: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (fail_flag && xosc_idle) |=> fail_flag);

   a_r1_unarmed_no_fail: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (!fail_flag && !(mon_en && src_sel_ext)) |=> !fail_flag);
endmodule

bind xosc_watch xosc_watch_chk i_chk (
   .sys_clk     (sys_clk),
   .rst_n       (rst_n),
   .mon_en      (mon_en),
   .src_sel_ext (src_sel_ext),
   .clr_wr      (clr_wr),
   .xosc_idle   (xosc_idle),
   .fail_flag   (fail_flag),
   .nmi_req     (nmi_req),
   .nmi_src     (nmi_src)
);

// File: tb/test_xosc_watch.sv
`timescale 1ns/1ps
module test_xosc_watch;
   localparam int LIM  = 64;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_clk = 1'b0;
   logic int_clk = 1'b0;
   logic mon_en = 1'b1;
   logic src_sel_ext = 1'b1;
   logic clr_wr = 1'b0;
   logic lf_clk, xosc_idle, fail_flag, nmi_req, nmi_src;

   bit ext_run = 1'b1;
   bit ext_hold = 1'b0;
   int n_tests = 0;
   int n_fail = 0;
   int nmi_cnt = 0;
   int glitch_cnt = 0;
   realtime last_t = 0.0;

   xosc_watch #(.TIMEOUT_CYCLES(LIM), .SYNC_STAGES(SYNC)) i_xosc_watch (
      .sys_clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .int_clk(int_clk),
      .mon_en(mon_en), .src_sel_ext(src_sel_ext), .clr_wr(clr_wr),
      .lf_clk(lf_clk), .xosc_idle(xosc_idle), .fail_flag(fail_flag),
      .nmi_req(nmi_req), .nmi_src(nmi_src));

   always #4 clk = ~clk;

   // external: 320 ns period, edges at 3 mod 8 ns; internal: 464 ns period, edges at 1 mod 8 ns
   initial begin
      #3;
      forever begin
         #160;
         if (ext_run) ext_clk = ~ext_clk;
         else         ext_clk = ext_hold;
      end
   end
   initial begin
      #1;
      forever begin
         #232;
         int_clk = ~int_clk;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model, updated at each rising edge
   bit mq[$];
   int m_cnt = 0;
   bit m_fail = 1'b0;
   bit m_nmi = 1'b0;
   initial begin
      for (int i = 0; i < SYNC + 1; i++) mq.push_back(1'b0);
   end

   always @(posedge clk) begin
      bit e, idle_o, set_e, clr_e;
      if (!rst_n) begin
         mq = {};
         for (int i = 0; i < SYNC + 1; i++) mq.push_back(1'b0);
         m_cnt = 0; m_fail = 1'b0; m_nmi = 1'b0;
      end else begin
         e = mq[0] ^ mq[1];
         mq.push_back(ext_clk);
         void'(mq.pop_front());
         idle_o = (m_cnt == LIM);
         set_e = mon_en && src_sel_ext && idle_o && !m_fail;
         clr_e = clr_wr && m_fail && !idle_o;
         m_nmi = set_e;
         if (set_e) m_fail = 1'b1;
         else if (clr_e) m_fail = 1'b0;
         if (clr_e || e) m_cnt = 0;
         else if (m_cnt != LIM) m_cnt++;
      end
   end

   always @(negedge clk) begin
      check(fail_flag == m_fail, "R2 fail_flag vs model", fail_flag, m_fail);
      check(nmi_req == m_nmi, "R6 nmi_req vs model", nmi_req, m_nmi);
      check(nmi_src == m_fail, "R6 nmi_src vs model", nmi_src, m_fail);
      check(xosc_idle == (m_cnt == LIM), "R4 xosc_idle vs model", xosc_idle, m_cnt == LIM);
      if (nmi_req) nmi_cnt++;
   end

   // R7: phase width on the output clock
   always @(lf_clk) begin
      if (rst_n && last_t > 0.0 && ($realtime - last_t) < 150.0) glitch_cnt++;
      last_t = $realtime;
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic follow(input bit want_ext, input string tag);
      int bad = 0;
      repeat (64) begin
         @(negedge clk);
         if (lf_clk !== (want_ext ? ext_clk : int_clk)) bad++;
      end
      check(bad == 0, tag, bad, 0);
   endtask

   task automatic write_clear();
      @(negedge clk); clr_wr = 1'b1;
      @(negedge clk); clr_wr = 1'b0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
   end

   initial begin
      cyc(5);
      // R10 reset state
      check(fail_flag == 0 && nmi_req == 0 && nmi_src == 0 && xosc_idle == 0,
            "R10 reset outputs", {fail_flag, nmi_req, nmi_src, xosc_idle}, 0);
      rst_n = 1'b1;
      cyc(400);
      check(xosc_idle == 0, "R4 idle low while toggling", xosc_idle, 0);
      follow(1'b1, "R9 healthy external selected");

      // stop low
      ext_hold = 1'b0; ext_run = 1'b0;
      cyc(200);
      check(fail_flag == 1, "R2 flag after stop low", fail_flag, 1);
      check(nmi_cnt == 1, "R6 one nmi pulse", nmi_cnt, 1);
      cyc(200);
      follow(1'b0, "R3 failover to internal");

      // clear while stopped is ignored
      write_clear();
      cyc(5);
      check(fail_flag == 1, "R5 clear ignored while idle", fail_flag, 1);
      follow(1'b0, "R5 output stays internal");

      ext_run = 1'b1;
      cyc(100);
      check(xosc_idle == 0, "R4 idle drops on restart", xosc_idle, 0);
      check(fail_flag == 1, "R2 flag sticky after restart", fail_flag, 1);
      write_clear();
      cyc(3);
      check(fail_flag == 0, "R5 clear accepted", fail_flag, 0);
      check(nmi_src == 0, "R6 source bit cleared", nmi_src, 0);
      cyc(400);
      follow(1'b1, "R8 back to external");

      // stop high
      ext_hold = 1'b1; ext_run = 1'b0;
      cyc(200);
      check(fail_flag == 1, "R2 flag after stop high", fail_flag, 1);
      check(nmi_cnt == 2, "R6 second nmi pulse", nmi_cnt, 2);
      cyc(200);
      follow(1'b0, "R3 failover from stuck high");
      ext_run = 1'b1;
      cyc(100);
      write_clear();
      cyc(400);
      check(fail_flag == 0, "R5 second clear", fail_flag, 0);
      follow(1'b1, "R8 back to external again");

      // monitor disabled
      mon_en = 1'b0;
      ext_hold = 1'b0; ext_run = 1'b0;
      cyc(200);
      check(xosc_idle == 1, "R4 idle with monitor off", xosc_idle, 1);
      check(fail_flag == 0 && nmi_cnt == 2, "R1 no failure with monitor off", fail_flag, 0);

      // internal selected, monitor on
      ext_run = 1'b1;
      cyc(100);
      src_sel_ext = 1'b0; mon_en = 1'b1;
      cyc(400);
      follow(1'b0, "R9 internal selected");
      ext_run = 1'b0;
      cyc(200);
      check(fail_flag == 0 && nmi_cnt == 2, "R1 no failure with internal selected", fail_flag, 0);
      check(xosc_idle == 1, "R4 idle with internal selected", xosc_idle, 1);

      check(glitch_cnt == 0, "R7 no short output phase", glitch_cnt, 0);
      summary();
   end
endmodule